// File: doc/BRIEF.md
# ESF Multiframe CRC-6 Generator and Checker

This block runs a six-bit cyclic redundancy check across each 24-frame extended superframe of a 1.544 Mbit/s stream. It is placed once on the transmit path, where its result is inserted into the following multiframe, and once on the receive path, where the check bits carried in the stream are compared against the value computed over the multiframe before. The line bits arrive one at a time with a qualifier. A strobe marks each framing bit, and a second strobe marks the framing bit that opens a multiframe. Frame alignment is done upstream, and line coding is handled elsewhere.

A mode input selects how framing bits enter the calculation. In the J1 variant they enter with the values they actually carry. In the T1 variant each one is replaced by a one. A force input corrupts the outgoing check bits so that the far end's error handling can be tested. Receive mismatches are counted in a saturating counter that a host reads as two halves.

Top module: `esf_crc6_unit`

## Requirements
- R1: After reset, `tx_crc`, `crc_err`, `err_hi` and `err_lo` are all zero.
- R2: With `j1_mode` low, every qualified bit of a multiframe is shifted into a CRC register. The register is cleared at the multiframe-start bit and uses the polynomial x^6+x+1, MSB first, with feedback = data XOR bit 5. Every framing bit (`fbit_stb` or `mf_start`) enters as a one. One cycle after the next `mf_start` bit, `tx_crc` holds the result, and `tx_crc[5]` is the bit sent first.
- R3: With `j1_mode` high, framing bits enter the CRC at the value present on `bit_in`. The rest of the behaviour is as in R2.
- R4: When `force_err` is high at a multiframe-start bit, the `tx_crc` loaded at that bit is the bitwise inverse of the true CRC. `tx_crc` changes only one cycle after a qualified multiframe-start bit.
- R5: The C bits are taken from the framing bits of frames 2, 6, 10, 14, 18 and 22, where frame 1 is the `mf_start` frame. The first of them is compared with CRC bit 5. At each multiframe start from the third one onwards, the six C bits of the multiframe just ended are compared with the CRC of the multiframe before it. A difference raises `crc_err` for exactly one cycle, one cycle after the start bit.
- R6: Each `crc_err` pulse adds one to an error counter of `CNT_W` bits (16 by default). The count stops at all ones. `err_hi` always shows the upper half of the counter.
- R7: A one-cycle `hi_rd` pulse copies the lower half of the counter into `err_lo`. The copy appears on the following cycle. `err_lo` does not change at any other time.
- R8: While `bit_vld` is low, `bit_in`, `fbit_stb` and `mf_start` have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Qualifies the bit and strobes this cycle |
| bit_in | input | 1 | Serial line bit |
| fbit_stb | input | 1 | Current bit is a framing bit |
| mf_start | input | 1 | Current bit is the framing bit of frame 1 |
| j1_mode | input | 1 | 1: framing bits at actual value; 0: framing bits as ones |
| force_err | input | 1 | Invert the check bits loaded at the next multiframe start |
| hi_rd | input | 1 | Host read of the high byte; snapshots the low byte |
| tx_crc | output | CRC_W | CRC of the previous multiframe, for insertion |
| crc_err | output | 1 | One-cycle pulse per mismatching multiframe |
| err_hi | output | CNT_W/2 | Upper half of the error counter |
| err_lo | output | CNT_W/2 | Lower half captured at the last high-byte read |

## Verification
`tx_crc` and `crc_err` are both registered on the multiframe-start bit, so each is due one clock after that bit. The bench samples them at the falling edge that follows, before it drives the next bit. `err_hi` moves on the same edge as the `crc_err` pulse. `err_lo` is due one clock after `hi_rd` and is sampled at the falling edge after the read cycle. The bench keeps a model of the CRC register, the received C bits and the count, updated bit by bit. It inserts idle cycles filled with junk strobes to confirm that unqualified cycles do not move any of these timings.

// File: rtl/esf_crc6_unit.sv
module esf_crc6_unit #(
  parameter int NFRAMES   = 24,
  parameter int CRC_W     = 6,
  parameter logic [CRC_W-1:0] POLY = 6'h03,
  parameter int CBIT_STEP = 4,
  parameter int CBIT_OFS  = 1,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             fbit_stb,
  input  logic             mf_start,
  input  logic             j1_mode,
  input  logic             force_err,
  input  logic             hi_rd,
  output logic [CRC_W-1:0] tx_crc,
  output logic             crc_err,
  output logic [CNT_W/2-1:0] err_hi,
  output logic [CNT_W/2-1:0] err_lo
);
  localparam int FIDX_W = $clog2(NFRAMES);
  localparam int HALF   = CNT_W / 2;

  logic [FIDX_W-1:0] fidx;
  logic [CRC_W-1:0]  crc_run, crc_prev, rx_c;
  logic [1:0]        seen;
  logic [CNT_W-1:0]  err_cnt;
  logic [HALF-1:0]   lo_snap;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = d ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  wire start    = bit_vld & mf_start;
  wire fbit     = fbit_stb | mf_start;
  wire din      = (fbit & ~j1_mode) ? 1'b1 : bit_in;
  wire [CRC_W-1:0] seed    = start ? '0 : crc_run;
  wire [CRC_W-1:0] crc_nxt = crc_step(seed, din);
  wire cpos     = bit_vld & fbit_stb & ~mf_start &
                  (((int'(fidx) + 1) % CBIT_STEP) == CBIT_OFS);
  wire mismatch = start & (seen == 2'd2) & (rx_c != crc_prev);
  wire cnt_full = &err_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fidx     <= '0;
      crc_run  <= '0;
      crc_prev <= '0;
      rx_c     <= '0;
      seen     <= '0;
      tx_crc   <= '0;
      crc_err  <= 1'b0;
      err_cnt  <= '0;
      lo_snap  <= '0;
    end else begin
      if (bit_vld)
        crc_run <= crc_nxt;
      if (start) begin
        crc_prev <= crc_run;
        tx_crc   <= crc_run ^ {CRC_W{force_err}};
        fidx     <= '0;
        if (seen != 2'd2)
          seen <= seen + 2'd1;
      end else if (bit_vld && fbit_stb && fidx != FIDX_W'(NFRAMES-1)) begin
        fidx <= fidx + 1'b1;
      end
      if (cpos)
        rx_c <= {rx_c[CRC_W-2:0], bit_in};
      crc_err <= mismatch;
      if (mismatch && !cnt_full)
        err_cnt <= err_cnt + 1'b1;
      if (hi_rd)
        lo_snap <= err_cnt[HALF-1:0];
    end
  end

  assign err_hi = err_cnt[CNT_W-1:HALF];
  assign err_lo = lo_snap;

  p_err_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> $past(start));
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !$past(start, 2)) |=> (!crc_err || $past(start)));
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_full |=> cnt_full);
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> (err_cnt == $past(err_cnt) + 1'b1) || cnt_full);
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_err |-> $stable(err_cnt));
  p_lo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rd |=> $stable(err_lo));
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(tx_crc));
endmodule

// File: tb/sim_esf_crc6_unit.sv
module sim_esf_crc6_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, fbit_stb = 1'b0, mf_start = 1'b0;
  logic j1_mode = 1'b0, force_err = 1'b0, hi_rd = 1'b0;
  wire [5:0] tx_crc, tx_crc1;
  wire crc_err, crc_err1;
  wire [7:0] err_hi, err_lo;
  wire [1:0] s_hi, s_lo;

  esf_crc6_unit u0 (.clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .fbit_stb(fbit_stb), .mf_start(mf_start), .j1_mode(j1_mode), .force_err(force_err),
    .hi_rd(hi_rd), .tx_crc(tx_crc), .crc_err(crc_err), .err_hi(err_hi), .err_lo(err_lo));

  esf_crc6_unit #(.CNT_W(4)) u1 (.clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .fbit_stb(fbit_stb), .mf_start(mf_start), .j1_mode(j1_mode), .force_err(force_err),
    .hi_rd(hi_rd), .tx_crc(tx_crc1), .crc_err(crc_err1), .err_hi(s_hi), .err_lo(s_lo));

  int checks = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [5:0] m_run = '0, m_prev = '0, c_cur = '0, exp_tx = '0;
  bit exp_err = 0, pend = 0;
  int starts = 0, n_err = 0;
  string cur_req = "R2";

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  function automatic logic [5:0] step(input logic [5:0] c, input bit d);
    return {c[4:0], 1'b0} ^ ((d ^ c[5]) ? 6'h03 : 6'h00);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic beat(input bit v, input bit b, input bit fb, input bit ms);
    bit d;
    @(negedge clk);
    if (pend) begin
      pend = 0;
      chk({cur_req, " tx_crc"}, 32'(tx_crc), 32'(exp_tx));
      chk("R5 crc_err", 32'(crc_err), 32'(exp_err));
      chk("R5 crc_err narrow", 32'(crc_err1), 32'(exp_err));
    end
    bit_vld = v; bit_in = b; fbit_stb = fb; mf_start = ms;
    if (v) begin
      d = ((fb || ms) && !j1_mode) ? 1'b1 : b;
      if (ms) begin
        exp_tx  = m_run ^ {6{force_err}};
        exp_err = (starts >= 2) && (c_cur != m_prev);
        if (exp_err) n_err++;
        m_prev = m_run;
        starts++;
        pend = 1;
        m_run = step(6'h00, d);
      end else begin
        m_run = step(m_run, d);
      end
    end
  endtask

  task automatic send_mf(input int pay, input bit gap, input bit bad);
    bit cb;
    for (int f = 0; f < 24; f++) begin
      if (gap) beat(0, rnd(), rnd(), rnd());
      if (f == 0) beat(1, rnd(), 1, 1);
      else if (f % 4 == 1) begin
        cb = m_prev[5 - f/4] ^ bad;
        c_cur = {c_cur[4:0], cb};
        beat(1, cb, 1, 0);
      end else beat(1, rnd(), 1, 0);
      for (int p = 0; p < pay; p++) begin
        if (gap && p % 3 == 0) beat(0, rnd(), rnd(), rnd());
        beat(1, rnd(), 0, 0);
      end
    end
  endtask

  task automatic rd_and_check(input string tag);
    @(negedge clk);
    bit_vld = 0; hi_rd = 1;
    @(negedge clk);
    hi_rd = 0;
    chk({tag, " err_hi"}, 32'(err_hi), 32'(n_err >> 8));
    chk({tag, " err_lo"}, 32'(err_lo), 32'(n_err & 8'hFF));
    chk({tag, " narrow sat"}, 32'({s_hi, s_lo}), 32'((n_err > 15) ? 15 : n_err));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 tx_crc", 32'(tx_crc), 0);
    chk("R1 crc_err", 32'(crc_err), 0);
    chk("R1 err_hi", 32'(err_hi), 0);
    chk("R1 err_lo", 32'(err_lo), 0);
  endtask

  task automatic t_t1();
    cur_req = "R2"; j1_mode = 0;
    for (int k = 0; k < 3; k++) send_mf(192, 0, 0);
  endtask

  task automatic t_gaps();
    cur_req = "R8";
    send_mf(20, 1, 0);
    send_mf(20, 1, 0);
  endtask

  task automatic t_j1();
    cur_req = "R3"; j1_mode = 1;
    send_mf(192, 0, 0);
    send_mf(40, 0, 0);
    send_mf(40, 0, 0);
    j1_mode = 0;
  endtask

  task automatic t_force();
    cur_req = "R4"; force_err = 1;
    send_mf(30, 0, 0);
    force_err = 0;
    send_mf(30, 0, 0);
    send_mf(30, 0, 0);
  endtask

  task automatic t_errors();
    cur_req = "R5";
    send_mf(10, 0, 1);
    send_mf(10, 0, 1);
    send_mf(10, 0, 0);
    rd_and_check("R7 first read");
    send_mf(10, 0, 1);
    send_mf(10, 0, 0);
    chk("R7 err_lo held without read", 32'(err_lo), 32'((n_err - 1) & 8'hFF));
    rd_and_check("R7 second read");
  endtask

  task automatic t_sat();
    cur_req = "R6";
    for (int k = 0; k < 18; k++) send_mf(2, 0, 1);
    send_mf(2, 0, 0);
    rd_and_check("R6 saturation");
  endtask

  initial begin
    t_reset();
    t_t1();
    t_gaps();
    t_j1();
    t_force();
    t_errors();
    t_sat();
    beat(1, 1'b1, 1, 1);
    beat(0, 1'b0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule